// File: doc/BRIEF.md
# Synchronous Transmitter with Idle Fill

This block serializes characters for a synchronous link. A CPU loads characters one at a time into a holding register through a write strobe with data. Each character moves into a shift register. Bits leave on the line output one per bit period of a 1X transmit clock, and the output changes only after a falling edge of that clock. Characters are 5 to 8 bits long and may carry an odd or even parity bit. Once the first character has gone out, the line never idles while the transmitter stays enabled. When the CPU has nothing ready, the block inserts fill characters whose pattern depends on the selected mode.

A send-prefix input makes the block send the contents of the DLE register ahead of the next data character. A ready flag tells the CPU that the holding register can take a character. An empty flag shows that the shift register is about to run out of CPU data and that fill is being sent. The transmitter runs only while the enable input is high and clear-to-send is low. When either condition is removed, the character already in the shift register is finished before the block stops.

The transmit clock is sampled in the system clock domain. A falling edge seen there advances the line by one bit.

Top module: `sync_tx_fill`

## Requirements
- R1: After reset, txd is 1, tx_ready is 0 and tx_empty is 0.
- R2: While tx_en=1 and cts_n=0 and no character has been loaded, txd stays 1, tx_ready is 1 and no fill is sent. Once a character is loaded, characters follow each other with no gap bits.
- R3: When a character ends and the holding register is empty, fill is sent. With transparent=1 the fill is DLE then SYN1, and transparent takes priority over single_syn. With transparent=0 and single_syn=1 the fill is SYN1. With transparent=0 and single_syn=0 the fill is SYN1 then SYN2.
- R4: A character has 5+char_len data bits (char_len 0..3) and is sent least significant bit first. With par_en=1, one parity bit follows the data. With par_even=1 the parity bit is the XOR of the data bits; with par_even=0 it is the inverse of that XOR.
- R5: tx_ready goes to 0 within two clock cycles of a write strobe. It returns to 1 when the held character moves into the shift register.
- R6: tx_empty is set at the start of the final bit of a character (the last data bit, or the parity bit when parity is on) if the transmitter is running and the holding register is empty. It stays set while fill is sent and is cleared by a write strobe.
- R7: With send_dle=1, a held character is preceded on the line by the DLE register contents. tx_ready stays 0 while that prefix is sent.
- R8: A two-character fill that has started is sent in full before a newly loaded data character.
- R9: When tx_en goes to 0 or cts_n goes to 1, the character in the shift register is finished. After that, txd stays 1 and tx_ready and tx_empty are 0.
- R10: txd changes only on the system clock cycle after a transmit-clock falling edge has been detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| txc | input | 1 | 1X transmit bit clock, sampled by clk |
| tx_en | input | 1 | Transmitter enable |
| cts_n | input | 1 | Clear to send, active low |
| char_len | input | 2 | Data length code: bits = 5 + code |
| par_en | input | 1 | Append a parity bit |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| single_syn | input | 1 | 1 = single SYN1 fill, 0 = SYN1 then SYN2 |
| transparent | input | 1 | 1 = DLE then SYN1 fill |
| send_dle | input | 1 | Prefix the held character with DLE |
| syn1 | input | 8 | First sync character |
| syn2 | input | 8 | Second sync character |
| dle | input | 8 | DLE character |
| wr_stb | input | 1 | Holding register write strobe |
| wr_data | input | 8 | Character to load |
| txd | output | 1 | Serial line output, idle high |
| tx_ready | output | 1 | Holding register can take a character |
| tx_empty | output | 1 | Fill condition flag |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, a minimum length of 5, a 2-bit length code and a 2-stage clock sampler. Under these defaults, all four character lengths and all three parity settings can be reached. A sweep of 192 back-to-back characters crosses those twelve framings with arithmetically generated values. The framing changes between characters on the fly, which exercises the capture of each character's framing when it is loaded. A directed stream then walks through the three fill patterns, the DLE prefix, a write that lands in the middle of a fill pair, and both ways of stopping the transmitter.

// File: rtl/tx_fill_pkg.sv
package tx_fill_pkg;
  // Source of the next character loaded into the shift register
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_DLE  = 2'd1,
    SRC_SYN1 = 2'd2,
    SRC_SYN2 = 2'd3
  } char_src_e;
endpackage

// File: rtl/txc_fall_detect.sv
module txc_fall_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic txc,
  output logic step
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-1:0], txc};
  end

  // older sample high, newer sample low: a falling edge
  assign step = pipe[STAGES] & ~pipe[STAGES-1];
endmodule

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      if (take)   full <= 1'b0;
      if (wr_stb) begin
        full <= 1'b1;
        data <= wr_data;
      end
    end
  end
endmodule

// File: rtl/tx_char_sequencer.sv
module tx_char_sequencer
  import tx_fill_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  logic      stop,
  input  logic      hold_full,
  input  logic      send_dle,
  input  logic      single_syn,
  input  logic      transparent,
  output char_src_e src,
  output logic      take
);
  logic      pend;
  char_src_e pend_src;
  logic      dle_done;
  logic      nxt_pend;
  char_src_e nxt_pend_src;
  logic      nxt_dle;

  always_comb begin
    src          = SRC_SYN1;
    nxt_pend     = 1'b0;
    nxt_pend_src = SRC_SYN1;
    nxt_dle      = dle_done;
    if (pend) begin
      src = pend_src;
    end else if (hold_full && send_dle && !dle_done) begin
      src     = SRC_DLE;
      nxt_dle = 1'b1;
    end else if (hold_full) begin
      src     = SRC_HOLD;
      nxt_dle = 1'b0;
    end else if (transparent) begin
      src          = SRC_DLE;
      nxt_pend     = 1'b1;
      nxt_pend_src = SRC_SYN1;
    end else if (!single_syn) begin
      src          = SRC_SYN1;
      nxt_pend     = 1'b1;
      nxt_pend_src = SRC_SYN2;
    end else begin
      src = SRC_SYN1;
    end
  end

  assign take = load && (src == SRC_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= 1'b0;
      pend_src <= SRC_SYN1;
      dle_done <= 1'b0;
    end else if (load) begin
      pend     <= nxt_pend;
      pend_src <= nxt_pend_src;
      dle_done <= nxt_dle;
    end else if (stop) begin
      pend <= 1'b0;
    end
  end
endmodule

// File: rtl/tx_frame_shifter.sv
module tx_frame_shifter #(
  parameter int DW      = 8,
  parameter int MIN_LEN = 5,
  parameter int LEN_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             load,
  input  logic             stop,
  input  logic [DW-1:0]    char_in,
  input  logic [LEN_W-1:0] char_len,
  input  logic             par_en,
  input  logic             par_even,
  output logic             txd,
  output logic             busy,
  output logic             char_end,
  output logic             enter_final
);
  localparam int SH_W  = DW + 1;
  localparam int CNT_W = $clog2(SH_W + 1);

  logic [CNT_W-1:0] len;
  logic [CNT_W-1:0] blen;
  logic [CNT_W-1:0] blen_q;
  logic [CNT_W-1:0] cnt;
  logic [SH_W-1:0]  word;
  logic [SH_W-1:0]  sh;
  logic             par_bit;

  assign len  = CNT_W'(MIN_LEN) + CNT_W'(char_len);
  assign blen = len + CNT_W'(par_en);

  always_comb begin
    word = '0;
    for (int i = 0; i < DW; i++) begin
      if (CNT_W'(i) < len) word[i] = char_in[i];
    end
    par_bit = (^word) ^ ~par_even;
    for (int i = 0; i < SH_W; i++) begin
      if (CNT_W'(i) == len) word[i] = par_en & par_bit;
    end
  end

  assign char_end    = step && busy && (cnt == blen_q - CNT_W'(1));
  assign enter_final = step && busy && (cnt == blen_q - CNT_W'(2));

  always_ff @(posedge clk) begin
    if (rst) begin
      txd    <= 1'b1;
      busy   <= 1'b0;
      sh     <= '0;
      cnt    <= '0;
      blen_q <= CNT_W'(MIN_LEN);
    end else if (load) begin
      txd    <= word[0];
      sh     <= word >> 1;
      cnt    <= '0;
      blen_q <= blen;
      busy   <= 1'b1;
    end else if (stop) begin
      txd  <= 1'b1;
      busy <= 1'b0;
    end else if (step && busy) begin
      txd <= sh[0];
      sh  <= sh >> 1;
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/sync_tx_fill.sv
module sync_tx_fill
  import tx_fill_pkg::*;
#(
  parameter int DW      = 8,
  parameter int MIN_LEN = 5,
  parameter int LEN_W   = 2,
  parameter int STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             txc,
  input  logic             tx_en,
  input  logic             cts_n,
  input  logic [LEN_W-1:0] char_len,
  input  logic             par_en,
  input  logic             par_even,
  input  logic             single_syn,
  input  logic             transparent,
  input  logic             send_dle,
  input  logic [DW-1:0]    syn1,
  input  logic [DW-1:0]    syn2,
  input  logic [DW-1:0]    dle,
  input  logic             wr_stb,
  input  logic [DW-1:0]    wr_data,
  output logic             txd,
  output logic             tx_ready,
  output logic             tx_empty
);
  logic          bit_step;
  logic          hold_full;
  logic [DW-1:0] hold_data;
  logic          take;
  logic          sh_busy;
  logic          char_end;
  logic          enter_final;
  logic          run;
  logic          load;
  logic          stop;
  char_src_e     src;
  logic [DW-1:0] next_char;

  assign run  = tx_en & ~cts_n;
  assign load = (char_end & run) | (bit_step & ~sh_busy & run & hold_full);
  assign stop = char_end & ~run;

  txc_fall_detect #(.STAGES(STAGES)) u_edge (
    .clk(clk), .rst(rst), .txc(txc), .step(bit_step)
  );

  tx_hold_reg #(.DW(DW)) u_hold (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
    .take(take), .full(hold_full), .data(hold_data)
  );

  tx_char_sequencer u_seq (
    .clk(clk), .rst(rst), .load(load), .stop(stop),
    .hold_full(hold_full), .send_dle(send_dle),
    .single_syn(single_syn), .transparent(transparent),
    .src(src), .take(take)
  );

  always_comb begin
    case (src)
      SRC_HOLD: next_char = hold_data;
      SRC_DLE:  next_char = dle;
      SRC_SYN2: next_char = syn2;
      default:  next_char = syn1;
    endcase
  end

  tx_frame_shifter #(.DW(DW), .MIN_LEN(MIN_LEN), .LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst(rst), .step(bit_step), .load(load), .stop(stop),
    .char_in(next_char), .char_len(char_len), .par_en(par_en),
    .par_even(par_even), .txd(txd), .busy(sh_busy),
    .char_end(char_end), .enter_final(enter_final)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_ready <= 1'b0;
      tx_empty <= 1'b0;
    end else begin
      tx_ready <= (run | sh_busy) & ~hold_full;
      if (wr_stb)                               tx_empty <= 1'b0;
      else if (!run && !sh_busy)                tx_empty <= 1'b0;
      else if (enter_final && run && !hold_full) tx_empty <= 1'b1;
    end
  end
endmodule

// File: rtl/tx_fill_checker.sv
module tx_fill_checker (
  input logic clk,
  input logic rst,
  input logic wr_stb,
  input logic txd,
  input logic tx_ready,
  input logic tx_empty,
  input logic step,
  input logic busy
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (txd && !tx_ready && !tx_empty));

  a_r5_ready_drops: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> ##2 !tx_ready);

  a_r6_empty_cleared: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !tx_empty);

  a_r6_empty_while_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_empty) |-> busy);

  a_r10_txd_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(txd) |-> $past(step));
endmodule

bind sync_tx_fill tx_fill_checker u_chk (
  .clk(clk), .rst(rst), .wr_stb(wr_stb), .txd(txd),
  .tx_ready(tx_ready), .tx_empty(tx_empty),
  .step(bit_step), .busy(sh_busy)
);

// File: tb/tb_sync_tx_fill.sv
`timescale 1ns/1ps
module tb_sync_tx_fill;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       txc = 1'b0;
  logic       tx_en = 1'b0;
  logic       cts_n = 1'b0;
  logic [1:0] char_len = 2'd3;
  logic       par_en = 1'b0;
  logic       par_even = 1'b0;
  logic       single_syn = 1'b1;
  logic       transparent = 1'b0;
  logic       send_dle = 1'b0;
  logic [7:0] syn1 = 8'h16;
  logic [7:0] syn2 = 8'h94;
  logic [7:0] dle = 8'h10;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       txd, tx_ready, tx_empty;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;
  logic [7:0] wr_val;
  logic [1:0] nxt_len;
  int         nxt_par;

  localparam int NSWEEP = 192;

  sync_tx_fill dut (
    .clk(clk), .rst(rst), .txc(txc), .tx_en(tx_en), .cts_n(cts_n),
    .char_len(char_len), .par_en(par_en), .par_even(par_even),
    .single_syn(single_syn), .transparent(transparent), .send_dle(send_dle),
    .syn1(syn1), .syn2(syn2), .dle(dle), .wr_stb(wr_stb), .wr_data(wr_data),
    .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty)
  );

  always #4 clk = ~clk;

  always begin
    repeat (8) @(negedge clk);
    txc = ~txc;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] frame(input logic [7:0] v, input int n, input int par);
    logic [8:0] w;
    int ones;
    w = '0;
    ones = 0;
    for (int i = 0; i < n; i++) begin
      w[i] = v[i];
      ones += int'(v[i]);
    end
    if (par != 0) w[n] = (par == 2) ? ones[0] : ~ones[0];
    return w;
  endfunction

  function automatic logic [7:0] sweep_val(input int k);
    return 8'((k * 53 + 7) ^ (k >> 2));
  endfunction

  task automatic get_bit(output logic b);
    @(posedge txc);
    repeat (2) @(negedge clk);
    b = txd;
  endtask

  task automatic write_char(input logic [7:0] v);
    @(negedge clk);
    wr_stb  = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_stb  = 1'b0;
  endtask

  task automatic do_act(input int act);
    case (act)
      1: write_char(wr_val);
      2: tx_en = 1'b0;
      3: cts_n = 1'b1;
      4: begin
        char_len = nxt_len;
        par_en   = (nxt_par != 0);
        par_even = (nxt_par == 2);
        write_char(wr_val);
      end
      5: begin
        send_dle = 1'b1;
        write_char(wr_val);
      end
      6: begin
        send_dle = 1'b0;
        check("R7 ready low during DLE prefix", 32'(tx_ready), 32'd0);
      end
      7: single_syn = 1'b0;
      8: transparent = 1'b1;
      default: ;
    endcase
  endtask

  task automatic read_char(input logic [8:0] exp, input int nb, input int act, input string tag);
    logic [8:0] got;
    logic b;
    got = '0;
    for (int i = 0; i < nb; i++) begin
      get_bit(b);
      got[i] = b;
      if (i == 0) do_act(act);
    end
    check(tag, 32'(got), 32'(exp));
  endtask

  task automatic idle_bits(input int n, input string tag);
    logic b;
    for (int i = 0; i < n; i++) begin
      get_bit(b);
      check(tag, 32'(b), 32'd1);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic b, b2;
    logic [8:0] ex;
    int cfg;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 txd after reset", 32'(txd), 32'd1);
    check("R1 ready after reset", 32'(tx_ready), 32'd0);
    check("R1 empty after reset", 32'(tx_empty), 32'd0);

    // R2: enabled, nothing loaded
    tx_en = 1'b1;
    idle_bits(3, "R2 line high before first char");
    check("R2 ready before first char", 32'(tx_ready), 32'd1);
    check("R2 no empty before first char", 32'(tx_empty), 32'd0);

    // R4/R5/R6/R10 on first character, 8 bits no parity
    write_char(8'hA5);
    repeat (2) @(negedge clk);
    check("R5 ready low after write", 32'(tx_ready), 32'd0);
    for (int i = 0; i < 8; i++) begin
      get_bit(b);
      check("R4 LSB-first bit of A5", 32'(b), 32'(((8'hA5 >> i) & 8'h01)));
      if (i == 0) check("R5 ready back after transfer", 32'(tx_ready), 32'd1);
      check("R6 empty at final bit only", 32'(tx_empty), (i == 7) ? 32'd1 : 32'd0);
      repeat (4) @(negedge clk);
      b2 = txd;
      check("R10 txd stable while txc high", 32'(b2), 32'(b));
    end

    // R3 single SYN fill, R6 held during fill
    read_char(frame(syn1, 8, 0), 8, 0, "R3 single fill SYN1");
    check("R6 empty held during fill", 32'(tx_empty), 32'd1);
    wr_val = 8'h77;
    read_char(frame(syn1, 8, 0), 8, 1, "R3 second single fill");
    check("R6 empty cleared by write", 32'(tx_empty), 32'd0);
    wr_val = 8'h3C;
    read_char(frame(8'h77, 8, 0), 8, 5, "R2 back-to-back data 77");
    read_char(frame(dle, 8, 0), 8, 6, "R7 DLE prefix");
    read_char(frame(8'h3C, 8, 0), 8, 0, "R7 data after prefix");
    read_char(frame(syn1, 8, 0), 8, 7, "R3 fill before mode switch");
    read_char(frame(syn1, 8, 0), 8, 0, "R3 double fill first");
    read_char(frame(syn2, 8, 0), 8, 0, "R3 double fill second");
    wr_val = 8'h5A;
    read_char(frame(syn1, 8, 0), 8, 1, "R8 pair start");
    read_char(frame(syn2, 8, 8), 8, 8, "R8 pair completed before data");
    read_char(frame(8'h5A, 8, 0), 8, 0, "R8 data after pair");
    read_char(frame(dle, 8, 0), 8, 0, "R3 transparent fill DLE");
    read_char(frame(syn1, 8, 0), 8, 0, "R3 transparent fill SYN1");
    read_char(frame(dle, 8, 0), 8, 2, "R9 char finished after disable");
    idle_bits(3, "R9 line high after disable");
    check("R9 ready inactive after disable", 32'(tx_ready), 32'd0);
    check("R9 empty inactive after disable", 32'(tx_empty), 32'd0);

    // R4 sweep over all lengths and parity settings, back to back
    transparent = 1'b0;
    single_syn  = 1'b1;
    char_len    = 2'd0;
    par_en      = 1'b0;
    par_even    = 1'b0;
    tx_en       = 1'b1;
    idle_bits(2, "R2 no fill after re-enable");
    write_char(sweep_val(0));
    for (int k = 0; k < NSWEEP; k++) begin
      cfg = k / 16;
      ex  = frame(sweep_val(k), 5 + (cfg % 4), cfg / 4);
      if (k < NSWEEP - 1) begin
        nxt_len = 2'(((k + 1) / 16) % 4);
        nxt_par = ((k + 1) / 16) / 4;
        wr_val  = sweep_val(k + 1);
        read_char(ex, 5 + (cfg % 4) + ((cfg / 4) != 0 ? 1 : 0), 4, "R4 sweep framing");
      end else begin
        read_char(ex, 5 + (cfg % 4) + ((cfg / 4) != 0 ? 1 : 0), 3, "R9 last char finished after cts high");
      end
    end
    idle_bits(2, "R9 line high after cts high");
    check("R9 ready inactive after cts high", 32'(tx_ready), 32'd0);
    check("R9 empty inactive after cts high", 32'(tx_empty), 32'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule